// File: doc/BRIEF.md
# Serial Security Key Access Controller

This block is the device end of a three-wire serial security key. A host raises an enable line, toggles a serial clock and exchanges bits over one bidirectional data line. On the chip, that line appears as an input, an output and an output enable. Every transfer opens with a 24-bit command word, and any field mismatch in that word aborts the transfer. A valid normal-mode command streams out a stored 64-bit identification code. It then takes in 64 bits that are compared with a stored 64-bit access code, and finally allows 128 bit-cycles of reading or writing a secure memory. A valid program-mode command instead loads a new identification code and a new access code.

The block runs on a fast system clock and treats the serial clock and the enable line as slow, already synchronous data inputs. Each edge of the serial clock is found by comparing it with its value one system clock earlier. The stored codes and the secure memory are plain registers that stand in for nonvolatile cells. When the access code does not match, reads in the memory phase return bits from a free-running 16-bit LFSR, and writes have no effect.

Top module: `skey_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `dq_oe` is 0. The identification code resets to `ID_INIT`, the access code to `CODE_INIT` and the secure memory to all zeros.
- R2: Bits are sampled on serial clock rises, least-significant first. Command bits [7:0], in order of arrival, must be 0,1,1,0,0,0,1,0 for read (8'h46) or 1,0,0,1,1,1,0,1 for write (8'hB9). Any other value aborts, and an aborted transfer never drives `dq_oe` until the enable is cycled.
- R3: Command bits {[9],[8]} = 2'b01 select normal mode and 2'b10 select program mode. Program mode is accepted only together with the write encoding. The values 2'b00 and 2'b11, and program mode with the read encoding, abort the transfer with no stored code changed.
- R4: The transfer aborts unless the select field {cmd[22:16], cmd[15:10]} equals the `DEV_SEL` parameter and cmd[23] is 1.
- R5: After an accepted normal command, the next 64 bit-cycles present identification bits 0..63. Each bit is driven with `dq_oe`=1 from the system cycle after a serial clock fall, and `dq_oe` returns to 0 on the system cycle after the following rise.
- R6: The next 64 bits written are compared with the access code. On a match, a read command then presents secure memory bits 0..127 over 128 bit-cycles.
- R7: On a match with a write command, the 128 bits written are stored into secure memory bits 0..127.
- R8: On a mismatch with a read command, the 128 memory-phase cycles still drive `dq_oe`, but the data comes from the LFSR. The stream is neither constant nor equal to the memory contents.
- R9: On a mismatch with a write command, the 128 memory-phase writes leave the secure memory unchanged.
- R10: In program mode, the 128 bits after the command become identification bits 0..63 and then access code bits 0..63.
- R11: Dropping `key_en` ends any transfer: `dq_oe` is 0 from the next system cycle on. The next rise of `key_en` starts a fresh command word.
- R12: After an abort or after the last data cycle, serial clock edges change nothing and never drive `dq_oe` until `key_en` goes low and high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_en | input | 1 | Transfer enable; high frames one transfer |
| sclk | input | 1 | Serial bit clock, sampled on `clk` |
| dq_in | input | 1 | Serial data from the host |
| dq_out | output | 1 | Serial data to the host |
| dq_oe | output | 1 | Output enable for the data line |

## Verification
The hardest cases to reach are the paths that follow a failed access-code comparison. Nothing at the ports reports the failure: reads simply carry noise, and writes leave no trace until a later transfer with the correct code reads the memory back. The stimulus therefore pairs every mismatch transfer with a matched read-back. It also runs a program transfer that changes the code between phases, so that an old code and a new code are each tried against both outcomes. The aborted-program case is shown the same way: a following transfer reads back the identification code and finds it unchanged.

// File: rtl/skey_pkg.sv
// Package for the serial security key controller.
// Holds the controller state encoding, the command classification and the
// fixed command-word layout constants shared by the design and its checker.
package skey_pkg;

    // Command word length and access-byte encodings (first-received bit is bit 0)
    localparam int          CMD_W     = 24;
    localparam int          SEL_W     = 13;
    localparam logic [7:0]  ACC_READ  = 8'h46;
    localparam logic [7:0]  ACC_WRITE = 8'hB9;
    localparam logic [1:0]  MODE_NORM = 2'b01;
    localparam logic [1:0]  MODE_PROG = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ID,
        ST_CMP,
        ST_MEM,
        ST_PROG,
        ST_HALT
    } skey_state_t;

    typedef enum logic [1:0] {
        CMD_ABORT,
        CMD_READ,
        CMD_WRITE,
        CMD_PROG
    } skey_cmd_t;

endpackage

// File: rtl/skey_edge.sv
// Edge finder for a slow input sampled on the system clock.
// Assumes the input is already synchronous to clk and holds each level
// for at least two system cycles.
module skey_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);

    logic sig_q;

    // Keep the previous sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;

endmodule

// File: rtl/skey_cmd_dec.sv
// Combinational classifier for a complete 24-bit command word.
// Assumes bit 0 is the first bit received. Any field mismatch yields CMD_ABORT.
module skey_cmd_dec
    import skey_pkg::*;
#(
    parameter logic [SEL_W-1:0] DEV_SEL = 13'h0A5
) (
    input  logic [CMD_W-1:0] word,
    output skey_cmd_t        kind
);

    logic [7:0]       acc;
    logic [1:0]       mode;
    logic [SEL_W-1:0] sel;

    assign acc  = word[7:0];
    assign mode = word[9:8];
    assign sel  = {word[22:16], word[15:10]};

    // Classify the word; select field and closing bit gate everything
    always_comb begin
        kind = CMD_ABORT;
        if (word[23] && sel == DEV_SEL) begin
            if (acc == ACC_READ && mode == MODE_NORM)       kind = CMD_READ;
            else if (acc == ACC_WRITE && mode == MODE_NORM) kind = CMD_WRITE;
            else if (acc == ACC_WRITE && mode == MODE_PROG) kind = CMD_PROG;
        end
    end

endmodule

// File: rtl/skey_lfsr.sv
// Free-running Galois LFSR, one step per system clock.
// Assumes SEED is nonzero. Bit 0 serves as the noise output.
module skey_lfsr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    output logic noise
);

    logic [W-1:0] q;
    logic [W-1:0] nxt;

    // Right-shift with tap feedback, one bit slice per position
    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i == W - 1) begin : g_top
            assign nxt[i] = TAPS[i] & q[0];
        end else begin : g_mid
            assign nxt[i] = q[i+1] ^ (TAPS[i] & q[0]);
        end
    end

    // Advance the register every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= nxt;
    end

    assign noise = q[0];

endmodule

// File: rtl/skey_ctrl.sv
// Serial security key controller (top).
// Runs the command, identification, compare, memory and program phases on
// serial clock edges detected in the system clock domain. Assumes key_en,
// sclk and dq_in are synchronous to clk and slow relative to it. Stored
// codes and secure memory are registers modelling nonvolatile cells.
module skey_ctrl
    import skey_pkg::*;
#(
    parameter int                 ID_W      = 64,
    parameter int                 CODE_W    = 64,
    parameter int                 MEM_W     = 128,
    parameter logic [SEL_W-1:0]   DEV_SEL   = 13'h0A5,
    parameter logic [ID_W-1:0]    ID_INIT   = 64'h0123_4567_89AB_CDEF,
    parameter logic [CODE_W-1:0]  CODE_INIT = 64'hFEED_FACE_CAFE_BEEF,
    parameter logic [15:0]        LFSR_SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_en,
    input  logic sclk,
    input  logic dq_in,
    output logic dq_out,
    output logic dq_oe
);

    localparam int PROG_LEN = ID_W + CODE_W;
    localparam int MAX_A    = (MEM_W > PROG_LEN) ? MEM_W : PROG_LEN;
    localparam int MAX_LEN  = (MAX_A > CMD_W) ? MAX_A : CMD_W;
    localparam int CNT_W    = $clog2(MAX_LEN);
    localparam int ID_AW    = $clog2(ID_W);
    localparam int CODE_AW  = $clog2(CODE_W);
    localparam int MEM_AW   = $clog2(MEM_W);

    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] LAST_ID   = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] LAST_CMP  = CNT_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] LAST_MEM  = CNT_W'(MEM_W - 1);
    localparam logic [CNT_W-1:0] LAST_PROG = CNT_W'(PROG_LEN - 1);
    localparam logic [CNT_W-1:0] ID_SPAN   = CNT_W'(ID_W);

    skey_state_t        st;
    logic [CNT_W-1:0]   cnt;
    logic [CMD_W-1:0]   cmd_sh;
    logic [CMD_W-1:0]   cmd_next;
    logic [CODE_W-1:0]  cmp_sh;
    logic [CODE_W-1:0]  cmp_next;
    logic               rd_mode;
    logic               matched;
    logic [ID_W-1:0]    id_q;
    logic [CODE_W-1:0]  code_q;
    logic [MEM_W-1:0]   mem_q;
    logic [CNT_W-1:0]   code_off;
    logic               s_rise;
    logic               s_fall;
    logic               noise;
    skey_cmd_t          kind;

    skey_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sclk),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    skey_lfsr #(
        .W    (16),
        .TAPS (16'hB400),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .noise (noise)
    );

    assign cmd_next = {dq_in, cmd_sh[CMD_W-1:1]};
    assign cmp_next = {dq_in, cmp_sh[CODE_W-1:1]};
    assign code_off = cnt - ID_SPAN;

    skey_cmd_dec #(
        .DEV_SEL (DEV_SEL)
    ) u_dec (
        .word (cmd_next),
        .kind (kind)
    );

    // Phase sequencer, data line driver and storage updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            cmd_sh  <= '0;
            cmp_sh  <= '0;
            rd_mode <= 1'b0;
            matched <= 1'b0;
            dq_oe   <= 1'b0;
            dq_out  <= 1'b0;
            id_q    <= ID_INIT;
            code_q  <= CODE_INIT;
            mem_q   <= '0;
        end else if (!key_en) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            dq_oe <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    st      <= ST_CMD;
                    cnt     <= '0;
                    matched <= 1'b0;
                    dq_oe   <= 1'b0;
                end
                ST_CMD: begin
                    if (s_rise) begin
                        cmd_sh <= cmd_next;
                        if (cnt == LAST_CMD) begin
                            cnt <= '0;
                            case (kind)
                                CMD_READ:  begin st <= ST_ID; rd_mode <= 1'b1; end
                                CMD_WRITE: begin st <= ST_ID; rd_mode <= 1'b0; end
                                CMD_PROG:  st <= ST_PROG;
                                default:   st <= ST_HALT;
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ID: begin
                    if (s_fall) begin
                        dq_oe  <= 1'b1;
                        dq_out <= id_q[cnt[ID_AW-1:0]];
                    end
                    if (s_rise) begin
                        dq_oe <= 1'b0;
                        if (cnt == LAST_ID) begin
                            cnt <= '0;
                            st  <= ST_CMP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_CMP: begin
                    if (s_rise) begin
                        cmp_sh <= cmp_next;
                        if (cnt == LAST_CMP) begin
                            matched <= (cmp_next == code_q);
                            cnt     <= '0;
                            st      <= ST_MEM;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_MEM: begin
                    if (s_fall && rd_mode) begin
                        dq_oe  <= 1'b1;
                        dq_out <= matched ? mem_q[cnt[MEM_AW-1:0]] : noise;
                    end
                    if (s_rise) begin
                        dq_oe <= 1'b0;
                        if (!rd_mode && matched) mem_q[cnt[MEM_AW-1:0]] <= dq_in;
                        if (cnt == LAST_MEM) begin
                            cnt <= '0;
                            st  <= ST_HALT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (s_rise) begin
                        if (cnt < ID_SPAN) id_q[cnt[ID_AW-1:0]] <= dq_in;
                        else               code_q[code_off[CODE_AW-1:0]] <= dq_in;
                        if (cnt == LAST_PROG) begin
                            cnt <= '0;
                            st  <= ST_HALT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    dq_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/skey_ctrl_chk.sv
// Assertion checker for skey_ctrl, attached by bind.
// Observes ports plus the phase state, mode flags and stored contents.
module skey_ctrl_chk
    import skey_pkg::*;
#(
    parameter int ID_W  = 64,
    parameter int MEM_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_en,
    input logic              sclk,
    input logic              dq_oe,
    input skey_state_t       st,
    input logic              rd_mode,
    input logic              matched,
    input logic [ID_W-1:0]   id_q,
    input logic [MEM_W-1:0]  mem_q
);

    // R11: a low enable releases the data line on the next cycle
    p_release_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !key_en |=> !dq_oe);

    // R5: a serial clock rise returns the line to high impedance
    p_release_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> !dq_oe);

    // R5: driving starts only one cycle after a detected serial clock fall
    p_drive_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (!$past(sclk) && $past(sclk, 2)));

    // R8, R12: the line is driven only in an identification or memory read phase
    p_drive_only_reading_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (st == ST_ID || (st == ST_MEM && rd_mode)));

    // R9: memory changes only during a matched write phase
    p_mem_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_MEM && !rd_mode && matched) |=> $stable(mem_q));

    // R10: the identification code changes only in program mode
    p_id_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_PROG) |=> $stable(id_q));

endmodule

bind skey_ctrl skey_ctrl_chk #(
    .ID_W  (ID_W),
    .MEM_W (MEM_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_en  (key_en),
    .sclk    (sclk),
    .dq_oe   (dq_oe),
    .st      (st),
    .rd_mode (rd_mode),
    .matched (matched),
    .id_q    (id_q),
    .mem_q   (mem_q)
);

// File: tb/skey_ctrl_test.sv
// Self-checking bench for skey_ctrl: a behavioural host plus a model of the
// stored codes and memory, checked in the middle of every serial half-cycle.
module skey_ctrl_test;

    localparam logic [12:0]  DEV   = 13'h0A5;
    localparam logic [63:0]  ID0   = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0]  CODE0 = 64'hFEED_FACE_CAFE_BEEF;
    localparam logic [7:0]   B_RD  = 8'h46;
    localparam logic [7:0]   B_WR  = 8'hB9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_en = 1'b0;
    logic sclk = 1'b0;
    logic dq_in = 1'b0;
    logic dq_out;
    logic dq_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic got;

    logic [63:0]  m_id   = ID0;
    logic [63:0]  m_code = CODE0;
    logic [127:0] m_mem  = '0;

    always #2 clk = ~clk;

    skey_ctrl #(
        .DEV_SEL   (DEV),
        .ID_INIT   (ID0),
        .CODE_INIT (CODE0)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_en (key_en),
        .sclk   (sclk),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] mk_cmd(input logic [7:0] b1, input logic [1:0] mode,
                                           input logic [12:0] dev, input logic top);
        return {top, dev[12:6], dev[5:0], mode, b1};
    endfunction

    // One host-write bit cycle; the line must stay released throughout
    task automatic wr_bit(input logic b, input string tag);
        sclk = 1'b0;
        wait_clk(4);
        chk(dq_oe == 1'b0, tag, dq_oe, 0);
        wait_clk(4);
        dq_in = b;
        sclk = 1'b1;
        wait_clk(4);
        chk(dq_oe == 1'b0, tag, dq_oe, 0);
        wait_clk(4);
    endtask

    // One host-read bit cycle; driven after the fall, released after the rise
    task automatic rd_bit(input logic exp, input bit use_exp, input string tag);
        sclk = 1'b0;
        wait_clk(4);
        chk(dq_oe == 1'b1, tag, dq_oe, 1);
        got = dq_out;
        if (use_exp) chk(dq_out == exp, tag, dq_out, exp);
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        chk(dq_oe == 1'b0, tag, dq_oe, 0);
        wait_clk(4);
    endtask

    task automatic start_xfer();
        key_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic end_xfer();
        key_en = 1'b0;
        wait_clk(4);
        sclk = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_cmd(input logic [23:0] w, input string tag);
        for (int i = 0; i < 24; i++) wr_bit(w[i], tag);
    endtask

    // Normal read: ID out, code in, then memory or noise
    task automatic normal_read(input logic [63:0] code_try, input string tag);
        logic [127:0] g;
        start_xfer();
        send_cmd(mk_cmd(B_RD, 2'b01, DEV, 1'b1), tag);
        for (int i = 0; i < 64; i++) rd_bit(m_id[i], 1, tag);
        for (int i = 0; i < 64; i++) wr_bit(code_try[i], tag);
        if (code_try == m_code) begin
            for (int i = 0; i < 128; i++) rd_bit(m_mem[i], 1, tag);
        end else begin
            for (int i = 0; i < 128; i++) begin
                rd_bit(1'b0, 0, "R8");
                g[i] = got;
            end
            chk(g != m_mem, "R8 noise equals memory", g, ~m_mem);
            chk(g != '0 && g != '1, "R8 noise constant", g, 0);
        end
        end_xfer();
    endtask

    // Normal write: ID out, code in, then 128 data bits and a few idle cycles
    task automatic normal_write(input logic [63:0] code_try, input logic [127:0] data, input string tag);
        start_xfer();
        send_cmd(mk_cmd(B_WR, 2'b01, DEV, 1'b1), tag);
        for (int i = 0; i < 64; i++) rd_bit(m_id[i], 1, tag);
        for (int i = 0; i < 64; i++) wr_bit(code_try[i], tag);
        for (int i = 0; i < 128; i++) wr_bit(data[i], tag);
        if (code_try == m_code) m_mem = data;
        for (int i = 0; i < 8; i++) wr_bit(1'b1, "R12");
        end_xfer();
    endtask

    task automatic program_key(input logic [63:0] nid, input logic [63:0] ncode);
        start_xfer();
        send_cmd(mk_cmd(B_WR, 2'b10, DEV, 1'b1), "R10");
        for (int i = 0; i < 64; i++) wr_bit(nid[i], "R10");
        for (int i = 0; i < 64; i++) wr_bit(ncode[i], "R10");
        m_id = nid;
        m_code = ncode;
        end_xfer();
    endtask

    // Rejected command followed by trailing cycles that must not drive
    task automatic abort_run(input logic [23:0] w, input int n, input logic [127:0] pat, input string tag);
        start_xfer();
        send_cmd(w, tag);
        for (int i = 0; i < n; i++) wr_bit(pat[i], tag);
        end_xfer();
    endtask

    localparam logic [127:0] P1   = 128'h5A5A_0F0F_1234_8765_C3C3_9696_F00D_0001;
    localparam logic [63:0]  ID2  = 64'hA1B2_C3D4_E5F6_0718;
    localparam logic [63:0]  CODE2 = 64'h1357_9BDF_2468_ACE0;

    initial begin
        // R1: reset state
        wait_clk(5);
        chk(dq_oe == 1'b0, "R1 oe in reset", dq_oe, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(dq_oe == 1'b0, "R1 oe after reset", dq_oe, 0);
        wait_clk(4);

        // R1, R5, R6: initial ID and zeroed memory via matched read
        normal_read(CODE0, "R6");
        // R7, R12: matched write, then idle cycles after the last data cycle
        normal_write(CODE0, P1, "R7");
        normal_read(CODE0, "R7");
        // R10: program new codes, check them back
        program_key(ID2, CODE2);
        normal_read(CODE2, "R10");
        // R8: mismatch read gives noise
        normal_read(CODE0, "R8");
        // R9: mismatch write ignored, memory read back intact
        normal_write(CODE0, ~P1, "R9");
        normal_read(CODE2, "R9");

        // R2: bad access byte
        abort_run(mk_cmd(8'h00, 2'b01, DEV, 1'b1), 64, '0, "R2");
        abort_run(mk_cmd(8'h47, 2'b01, DEV, 1'b1), 64, '0, "R2");
        // R3: bad mode values and program with read encoding
        abort_run(mk_cmd(B_RD, 2'b11, DEV, 1'b1), 64, '0, "R3");
        abort_run(mk_cmd(B_WR, 2'b00, DEV, 1'b1), 64, '0, "R3");
        abort_run(mk_cmd(B_RD, 2'b10, DEV, 1'b1), 128, {CODE0, ID0}, "R3");
        normal_read(CODE2, "R3");
        // R4: wrong select field, closing bit low
        abort_run(mk_cmd(B_RD, 2'b01, DEV ^ 13'h001, 1'b1), 64, '0, "R4");
        abort_run(mk_cmd(B_RD, 2'b01, DEV ^ 13'h1000, 1'b1), 64, '0, "R4");
        abort_run(mk_cmd(B_RD, 2'b01, DEV, 1'b0), 64, '0, "R4");

        // R11: drop enable while the line is driven
        start_xfer();
        send_cmd(mk_cmd(B_RD, 2'b01, DEV, 1'b1), "R11");
        for (int i = 0; i < 10; i++) rd_bit(m_id[i], 1, "R11");
        sclk = 1'b0;
        wait_clk(4);
        chk(dq_oe == 1'b1, "R11 driven before drop", dq_oe, 1);
        key_en = 1'b0;
        wait_clk(2);
        chk(dq_oe == 1'b0, "R11 released after drop", dq_oe, 0);
        wait_clk(4);
        normal_read(CODE2, "R11");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule